// File: doc/BRIEF.md
# Fly-By DMA Request Controller

This block lives in a peripheral that holds several endpoint FIFOs behind an 8-bit parallel host bus. It raises a demand-mode request line toward an external fly-by DMA controller. When that controller acknowledges and strobes a read or write, the block moves exactly one byte between the data bus and the FIFO of the endpoint chosen as DMA source. The FIFO address comes from inside the block, not from the bus address pin. Ordinary chip-select register accesses share the same strobes and always take precedence over DMA.

Firmware chooses one source endpoint, its direction and the trigger policy. The trigger policy is one of three: an immediate request, a request on the FIFO warning level, or a request on packet completion. Firmware then sets the request enable. The request is held for as long as the trigger condition holds and the FIFO can still serve a byte. Clearing the enable stops further requests, but a strobe already in progress finishes first.

Top module: `dma_req_ctrl`

## Requirements
- R1: Only endpoints 1 to 6 can source a request. Selecting endpoint 0 or 7 keeps `drq_o` low. `fifo_ep_o` reports the endpoint that is currently latched as the DMA source.
- R2: During a DMA strobe, `addr_i` has no effect. The FIFO transfer goes to the latched endpoint, and no register strobe is issued.
- R3: While `serial_mode_i` is high, `drq_o` stays low.
- R4: When `cs_i` is high at a strobe, `dack_i` is ignored. A read strobe gives one `reg_rd_o` pulse, a write strobe gives one `reg_wr_o` pulse, and no FIFO pop or push occurs.
- R5: An acknowledged read strobe in the receive direction (`dma_dir_i`=0) pops one byte. While the strobe lasts, `fifo_rdata_i` is driven on `data_o` with `data_oe_o` high. An acknowledged write strobe in the transmit direction (`dma_dir_i`=1) pushes one byte and presents `data_i` on `fifo_wdata_o`.
- R6: A request needs a trigger. The trigger is one of three: `dma_imm_i`, the selected endpoint's warning bit while `warn_en_i` is set, or the selected endpoint's packet-done bit. A warning bit is ignored while `warn_en_i` is low.
- R7: Clearing `dma_en_i` when no strobe is active drops `drq_o` within two cycles. Clearing it during a strobe keeps `drq_o` high until the strobe ends.
- R8: An acknowledged strobe with `cs_i` low does nothing while `drq_o` is low.
- R9: A request also needs the selected endpoint's bit in `ep_en_i`.
- R10: In the receive direction, a request is blocked while the endpoint's `rx_empty_i` bit is set. In the transmit direction, it is blocked while the endpoint's `tx_full_i` bit is set. The opposite flag has no effect.
- R11: A strobe moves exactly one byte, however many cycles it stays high.
- R12: A new `dma_ep_i` value is taken only while `drq_o` is low, no strobe is active and no trigger holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| serial_mode_i | input | 1 | Bus mode strap; high disables DMA |
| dma_en_i | input | 1 | DMA request enable |
| dma_ep_i | input | 3 | Requested source endpoint |
| dma_dir_i | input | 1 | 0 receive (pop), 1 transmit (push) |
| dma_imm_i | input | 1 | Immediate-request mode |
| warn_en_i | input | 1 | Warning-level trigger enable |
| ep_en_i | input | 8 | Per-endpoint enable |
| fifo_warn_i | input | 8 | Per-endpoint FIFO warning level reached |
| pkt_done_i | input | 8 | Per-endpoint packet complete |
| rx_empty_i | input | 8 | Per-endpoint receive FIFO empty |
| tx_full_i | input | 8 | Per-endpoint transmit FIFO full |
| cs_i | input | 1 | Chip select, active high |
| dack_i | input | 1 | DMA acknowledge |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 1 | Bus address pin |
| data_i | input | 8 | Bus write data |
| data_o | output | 8 | Bus read data |
| data_oe_o | output | 1 | Bus drive enable |
| fifo_rdata_i | input | 8 | Receive FIFO head byte |
| fifo_wdata_o | output | 8 | Transmit FIFO write byte |
| fifo_pop_o | output | 1 | One-cycle receive pop |
| fifo_push_o | output | 1 | One-cycle transmit push |
| fifo_ep_o | output | 3 | Latched DMA endpoint (internal FIFO address) |
| reg_rd_o | output | 1 | One-cycle register read |
| reg_wr_o | output | 1 | One-cycle register write |
| reg_addr_o | output | 1 | Address captured for register access |
| drq_o | output | 1 | DMA request |

## Verification
A table sweeps the request condition. Each row changes one input from a requesting baseline: the endpoint number at both edges of the legal range, the endpoint enable, the mode strap, each trigger source with and without the warning enable, and the full and empty flags in both directions. A failing row therefore points at one term of the request equation. Directed strobe sequences then separate DMA reads, DMA writes, chip-select register accesses and unrequested acknowledges. They count pulses over a long strobe to catch multiple transfers per strobe. They also clear the enable and change the endpoint select in the middle of a strobe, which tells deferred release apart from immediate release.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;
endpackage

// File: rtl/dma_sync.sv
module dma_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dma_trigger.sv
module dma_trigger
  import dma_req_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int EP_LO  = 1,
  parameter int EP_HI  = 6,
  localparam int EPW   = $clog2(NUM_EP)
) (
  input  logic              serial_mode_i,
  input  logic              dma_en_i,
  input  logic [EPW-1:0]    ep_i,
  input  dir_e              dir_i,
  input  logic              imm_i,
  input  logic              warn_en_i,
  input  logic [NUM_EP-1:0] ep_en_i,
  input  logic [NUM_EP-1:0] fifo_warn_i,
  input  logic [NUM_EP-1:0] pkt_done_i,
  input  logic [NUM_EP-1:0] rx_empty_i,
  input  logic [NUM_EP-1:0] tx_full_i,
  output logic              trig_o
);
  localparam logic [EPW-1:0] LO_V = EPW'(EP_LO);
  localparam logic [EPW-1:0] HI_V = EPW'(EP_HI);

  logic ep_ok, cause, blocked;

  always_comb begin
    ep_ok   = (ep_i >= LO_V) && (ep_i <= HI_V) && ep_en_i[ep_i];
    cause   = imm_i || (warn_en_i && fifo_warn_i[ep_i]) || pkt_done_i[ep_i];
    blocked = (dir_i == DIR_RX) ? rx_empty_i[ep_i] : tx_full_i[ep_i];
    trig_o  = !serial_mode_i && dma_en_i && ep_ok && cause && !blocked;
  end
endmodule

// File: rtl/dma_cycle.sv
module dma_cycle
  import dma_req_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int DW     = 8,
  parameter int AW     = 1,
  localparam int EPW   = $clog2(NUM_EP)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_s_i,
  input  logic           dack_s_i,
  input  logic           rd_s_i,
  input  logic           wr_s_i,
  input  logic           trig_i,
  input  logic [EPW-1:0] dma_ep_i,
  input  dir_e           dma_dir_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  data_i,
  output logic [EPW-1:0] ep_o,
  output dir_e           dir_o,
  output logic           drq_o,
  output logic           busy_o,
  output logic           pop_o,
  output logic           push_o,
  output logic           reg_rd_o,
  output logic           reg_wr_o,
  output logic [AW-1:0]  reg_addr_o,
  output logic [DW-1:0]  wdata_o
);
  logic rd_q, wr_q, rise_rd, rise_wr, dma_ok, pop_d, push_d;

  assign rise_rd = rd_s_i && !rd_q;
  assign rise_wr = wr_s_i && !wr_q;
  assign dma_ok  = !cs_s_i && dack_s_i && drq_o;
  assign pop_d   = rise_rd && dma_ok && (dir_o == DIR_RX);
  assign push_d  = rise_wr && dma_ok && (dir_o == DIR_TX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q       <= 1'b0;
      wr_q       <= 1'b0;
      pop_o      <= 1'b0;
      push_o     <= 1'b0;
      reg_rd_o   <= 1'b0;
      reg_wr_o   <= 1'b0;
      reg_addr_o <= '0;
      wdata_o    <= '0;
      busy_o     <= 1'b0;
      drq_o      <= 1'b0;
      ep_o       <= '0;
      dir_o      <= DIR_RX;
    end else begin
      rd_q     <= rd_s_i;
      wr_q     <= wr_s_i;
      pop_o    <= pop_d;
      push_o   <= push_d;
      reg_rd_o <= rise_rd && cs_s_i;
      reg_wr_o <= rise_wr && cs_s_i;
      if ((rise_rd || rise_wr) && cs_s_i) reg_addr_o <= addr_i;
      if (push_d) wdata_o <= data_i;
      if (pop_d || push_d) busy_o <= 1'b1;
      else if (!rd_s_i && !wr_s_i) busy_o <= 1'b0;
      // an in-flight strobe holds the request level
      if (!busy_o) drq_o <= trig_i;
      if (!busy_o && !drq_o && !trig_i) begin
        ep_o  <= dma_ep_i;
        dir_o <= dma_dir_i;
      end
    end
  end
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter int NUM_EP      = 8,
  parameter int DW          = 8,
  parameter int AW          = 1,
  parameter int EP_LO       = 1,
  parameter int EP_HI       = 6,
  parameter int SYNC_STAGES = 2,
  localparam int EPW        = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              serial_mode_i,
  input  logic              dma_en_i,
  input  logic [EPW-1:0]    dma_ep_i,
  input  logic              dma_dir_i,
  input  logic              dma_imm_i,
  input  logic              warn_en_i,
  input  logic [NUM_EP-1:0] ep_en_i,
  input  logic [NUM_EP-1:0] fifo_warn_i,
  input  logic [NUM_EP-1:0] pkt_done_i,
  input  logic [NUM_EP-1:0] rx_empty_i,
  input  logic [NUM_EP-1:0] tx_full_i,
  input  logic              cs_i,
  input  logic              dack_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     data_i,
  output logic [DW-1:0]     data_o,
  output logic              data_oe_o,
  input  logic [DW-1:0]     fifo_rdata_i,
  output logic [DW-1:0]     fifo_wdata_o,
  output logic              fifo_pop_o,
  output logic              fifo_push_o,
  output logic [EPW-1:0]    fifo_ep_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [AW-1:0]     reg_addr_o,
  output logic              drq_o
);
  logic [3:0] strb_s;
  logic       trig, cyc_busy;
  dir_e       cyc_dir;

  dma_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_i, dack_i, rd_i, wr_i}),
    .q_o   (strb_s)
  );

  dma_trigger #(.NUM_EP(NUM_EP), .EP_LO(EP_LO), .EP_HI(EP_HI)) u_trig (
    .serial_mode_i(serial_mode_i),
    .dma_en_i     (dma_en_i),
    .ep_i         (fifo_ep_o),
    .dir_i        (cyc_dir),
    .imm_i        (dma_imm_i),
    .warn_en_i    (warn_en_i),
    .ep_en_i      (ep_en_i),
    .fifo_warn_i  (fifo_warn_i),
    .pkt_done_i   (pkt_done_i),
    .rx_empty_i   (rx_empty_i),
    .tx_full_i    (tx_full_i),
    .trig_o       (trig)
  );

  dma_cycle #(.NUM_EP(NUM_EP), .DW(DW), .AW(AW)) u_cycle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_s_i    (strb_s[3]),
    .dack_s_i  (strb_s[2]),
    .rd_s_i    (strb_s[1]),
    .wr_s_i    (strb_s[0]),
    .trig_i    (trig),
    .dma_ep_i  (dma_ep_i),
    .dma_dir_i (dir_e'(dma_dir_i)),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .ep_o      (fifo_ep_o),
    .dir_o     (cyc_dir),
    .drq_o     (drq_o),
    .busy_o    (cyc_busy),
    .pop_o     (fifo_pop_o),
    .push_o    (fifo_push_o),
    .reg_rd_o  (reg_rd_o),
    .reg_wr_o  (reg_wr_o),
    .reg_addr_o(reg_addr_o),
    .wdata_o   (fifo_wdata_o)
  );

  assign data_oe_o = cyc_busy && (cyc_dir == DIR_RX);
  assign data_o    = data_oe_o ? fifo_rdata_i : '0;
endmodule

// File: rtl/dma_req_chk.sv
module dma_req_chk #(
  parameter int EPW   = 3,
  parameter int EP_LO = 1,
  parameter int EP_HI = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           serial_mode_i,
  input logic           drq_o,
  input logic           busy_i,
  input logic           fifo_pop_o,
  input logic           fifo_push_o,
  input logic           reg_rd_o,
  input logic           reg_wr_o,
  input logic           data_oe_o,
  input logic [EPW-1:0] fifo_ep_o
);
  AST_EP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drq_o |-> (int'(fifo_ep_o) >= EP_LO && int'(fifo_ep_o) <= EP_HI)); // R1
  AST_SERIAL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serial_mode_i && !busy_i) |=> !drq_o); // R3
  AST_ONE_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fifo_pop_o, fifo_push_o, reg_rd_o || reg_wr_o})); // R4
  AST_OE_ON_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> fifo_pop_o); // R5
  AST_HOLD_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && drq_o) |=> drq_o); // R7
  AST_XFER_NEEDS_DRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_pop_o || fifo_push_o) |-> $past(drq_o)); // R8
  AST_EP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(fifo_ep_o)); // R12
endmodule

bind dma_req_ctrl dma_req_chk #(.EPW(EPW), .EP_LO(EP_LO), .EP_HI(EP_HI)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .serial_mode_i(serial_mode_i),
  .drq_o        (drq_o),
  .busy_i       (cyc_busy),
  .fifo_pop_o   (fifo_pop_o),
  .fifo_push_o  (fifo_push_o),
  .reg_rd_o     (reg_rd_o),
  .reg_wr_o     (reg_wr_o),
  .data_oe_o    (data_oe_o),
  .fifo_ep_o    (fifo_ep_o)
);

// File: tb/tb_dma_req_ctrl.sv
`timescale 1ns/1ps
module tb_dma_req_ctrl;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       serial_mode, dma_en, dma_dir, dma_imm, warn_en;
  logic [2:0] dma_ep;
  logic [7:0] ep_en, fifo_warn, pkt_done, rx_empty, tx_full;
  logic       cs, dack, rd, wr;
  logic [0:0] addr;
  logic [7:0] data_in, data_out, fifo_rdata, fifo_wdata;
  logic       data_oe, pop, push, reg_rd, reg_wr, drq;
  logic [2:0] fifo_ep;
  logic [0:0] reg_addr;

  int checks = 0, fails = 0;
  int pop_n = 0, push_n = 0, rrd_n = 0, rwr_n = 0;

  always #2.5 clk = ~clk;

  dma_req_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .serial_mode_i(serial_mode), .dma_en_i(dma_en),
    .dma_ep_i(dma_ep), .dma_dir_i(dma_dir), .dma_imm_i(dma_imm), .warn_en_i(warn_en),
    .ep_en_i(ep_en), .fifo_warn_i(fifo_warn), .pkt_done_i(pkt_done),
    .rx_empty_i(rx_empty), .tx_full_i(tx_full), .cs_i(cs), .dack_i(dack),
    .rd_i(rd), .wr_i(wr), .addr_i(addr), .data_i(data_in), .data_o(data_out),
    .data_oe_o(data_oe), .fifo_rdata_i(fifo_rdata), .fifo_wdata_o(fifo_wdata),
    .fifo_pop_o(pop), .fifo_push_o(push), .fifo_ep_o(fifo_ep),
    .reg_rd_o(reg_rd), .reg_wr_o(reg_wr), .reg_addr_o(reg_addr), .drq_o(drq)
  );

  always_ff @(posedge clk) begin
    if (pop)    pop_n  <= pop_n + 1;
    if (push)   push_n <= push_n + 1;
    if (reg_rd) rrd_n  <= rrd_n + 1;
    if (reg_wr) rwr_n  <= rwr_n + 1;
  end

  typedef struct packed {
    logic ser, en, epen; logic [2:0] ep;
    logic dir, imm, wen, warn, done, empty, full, exp;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{1'b0,1'b1,1'b1,3'd2,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1}, // R6 immediate
    '{1'b1,1'b1,1'b1,3'd2,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R3 serial
    '{1'b0,1'b1,1'b1,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R1 ep0
    '{1'b0,1'b1,1'b1,3'd7,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R1 ep7
    '{1'b0,1'b1,1'b1,3'd6,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1}, // R1 ep6
    '{1'b0,1'b1,1'b0,3'd3,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R9
    '{1'b0,1'b1,1'b1,3'd4,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1}, // R6 warn on
    '{1'b0,1'b1,1'b1,3'd4,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0}, // R6 warn off
    '{1'b0,1'b1,1'b1,3'd5,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1}, // R6 done
    '{1'b0,1'b1,1'b1,3'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0}, // R10 rx empty
    '{1'b0,1'b1,1'b1,3'd1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R10 tx full
    '{1'b0,1'b1,1'b1,3'd1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1}, // R10 empty ignored tx
    '{1'b0,1'b1,1'b1,3'd2,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0}  // R6 no cause
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [2:0] ep, input logic dir);
    dma_en = 1'b0; dma_ep = ep; dma_dir = dir; dma_imm = 1'b1;
    ep_en = 8'hFF; warn_en = 1'b0; fifo_warn = '0; pkt_done = '0;
    rx_empty = '0; tx_full = '0; serial_mode = 1'b0;
    tick(3);
    dma_en = 1'b1;
    tick(3);
  endtask

  task automatic strobe(input logic c, input logic a, input logic is_rd, input int len);
    cs = c; dack = a;
    if (is_rd) rd = 1'b1; else wr = 1'b1;
    tick(len);
    rd = 1'b0; wr = 1'b0;
    tick(6);
    cs = 1'b0; dack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    serial_mode = 0; dma_en = 0; dma_ep = 0; dma_dir = 0; dma_imm = 0; warn_en = 0;
    ep_en = 0; fifo_warn = 0; pkt_done = 0; rx_empty = 0; tx_full = 0;
    cs = 0; dack = 0; rd = 0; wr = 0; addr = 0; data_in = 0; fifo_rdata = 8'hA5;
    tick(3);
    rst_ni = 1'b1;
    tick(3);
    check("reset drq", drq, 0);
    check("reset oe", data_oe, 0);
    check("reset pulses", pop_n + push_n + rrd_n + rwr_n, 0);

    foreach (VECS[i]) begin
      dma_en = 1'b0; serial_mode = VECS[i].ser; dma_ep = VECS[i].ep; dma_dir = VECS[i].dir;
      dma_imm = VECS[i].imm; warn_en = VECS[i].wen;
      ep_en = VECS[i].epen ? (8'd1 << VECS[i].ep) : 8'd0;
      fifo_warn = VECS[i].warn ? (8'd1 << VECS[i].ep) : 8'd0;
      pkt_done  = VECS[i].done ? (8'd1 << VECS[i].ep) : 8'd0;
      rx_empty  = VECS[i].empty ? (8'd1 << VECS[i].ep) : 8'd0;
      tx_full   = VECS[i].full ? (8'd1 << VECS[i].ep) : 8'd0;
      tick(3);
      dma_en = VECS[i].en;
      tick(3);
      check($sformatf("R1 R3 R6 R9 R10 vec%0d drq", i), drq, VECS[i].exp);
    end

    // R5 R11 R2: long read strobe with addr high pops one byte on ep 2
    setup(3'd2, 1'b0);
    check("R5 drq before read", drq, 1);
    addr = 1'b1; dack = 1'b1; rd = 1'b1;
    tick(6);
    check("R5 oe during read", data_oe, 1);
    check("R5 data during read", data_out, 8'hA5);
    check("R2 ep during read", fifo_ep, 2);
    rd = 1'b0; dack = 1'b0;
    tick(6);
    check("R11 one pop", pop_n, 1);
    check("R2 no reg strobe", rrd_n + rwr_n, 0);
    check("R5 oe after read", data_oe, 0);
    addr = 1'b0;

    // R5 write into tx FIFO of ep 3
    setup(3'd3, 1'b1);
    data_in = 8'h3C;
    strobe(1'b0, 1'b1, 1'b0, 4);
    check("R5 one push", push_n, 1);
    check("R5 wdata", fifo_wdata, 8'h3C);

    // R4 chip select wins over acknowledge
    addr = 1'b1;
    strobe(1'b1, 1'b1, 1'b1, 3);
    check("R4 reg read", rrd_n, 1);
    check("R4 no pop", pop_n, 1);
    check("R4 reg addr", reg_addr, 1);
    strobe(1'b1, 1'b1, 1'b0, 3);
    check("R4 reg write", rwr_n, 1);
    check("R4 no push", push_n, 1);
    addr = 1'b0;

    // R8 no request, acknowledged strobe does nothing
    dma_en = 1'b0;
    tick(3);
    strobe(1'b0, 1'b1, 1'b0, 3);
    check("R8 no push", push_n, 1);
    check("R8 no reg", rrd_n + rwr_n, 2);

    // R7 enable cleared mid strobe, then idle
    setup(3'd2, 1'b0);
    dack = 1'b1; rd = 1'b1;
    tick(6);
    dma_en = 1'b0;
    // R12 endpoint change deferred during strobe
    dma_ep = 3'd4;
    tick(3);
    check("R7 drq held in strobe", drq, 1);
    check("R12 ep held", fifo_ep, 2);
    rd = 1'b0; dack = 1'b0;
    tick(6);
    check("R7 drq after strobe", drq, 0);
    check("R12 ep taken when idle", fifo_ep, 4);
    check("R11 pop count", pop_n, 2);

    // R7 clear while idle
    setup(3'd5, 1'b0);
    dma_en = 1'b0;
    tick(2);
    check("R7 drq idle clear", drq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule